// File: doc/BRIEF.md
# GPIO Port Register Block

This block holds the software-visible state of a general-purpose I/O port: an output latch, a direction register, a captured copy of the pin levels, and one configuration word per pin. A simple single-cycle bus (valid, write, address, write data) reaches all of them. The output latch and the direction register each answer at three addresses: one replaces the value, one sets the bits that are 1 in the written data, and one clears them. This lets software change some pins without a read-modify-write sequence.

Direction appears in two places: as a whole register and as bit 0 of every pin's configuration word. Both views stay coherent. A direction write changes bit 0 of the configuration words, and a configuration write changes the matching direction bit. The latch, the direction and the configuration words go out as flat vectors to the pin logic, which lies outside this block. Only aligned 32-bit words are accepted. Any other access reports an error and changes no state.

Top module: `gpio_port_regs`

## Requirements
- R1: A write to address 0x504 replaces the output latch with the write data, and `out_o` shows the new value in the cycle after the access.
- R2: A write to address 0x508 ORs the write data into the output latch.
- R3: A write to address 0x50C clears the latch bits that are 1 in the write data and leaves the others unchanged.
- R4: The direction register changes by replace at 0x514, by OR-in at 0x518 and by clear-where-1 at 0x51C.
- R5: After any direction write, bit 0 of configuration word n (address 0x700 + 4n) reads as direction bit n. Bits 31..1 of the word are not changed.
- R6: A write to configuration word n stores all 32 bits and sets direction bit n to write-data bit 0. The other direction bits are not changed.
- R7: A read of 0x504, 0x508 or 0x50C returns the output latch. A read of 0x514, 0x518 or 0x51C returns the direction register.
- R8: Address 0x510 returns the pin levels, which are registered once per clock. A write to 0x510 is an unmapped access.
- R9: An access that is unmapped or whose address is not a multiple of 4 reads 0, leaves the latch, direction and configuration unchanged, and sets `rsp_err` for one cycle.
- R10: Reset clears the latch, the direction register and the pin capture to 0, sets every configuration word to 0x00000002, and clears `rsp_err`.
- R11: Read data and the error flag appear in the cycle after the access. `rsp_rdata` holds its value until the next read, and `rsp_err` is 0 after any cycle without an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address of the access |
| req_wdata | input | 32 | Write data |
| pad_in | input | 32 | Pin levels from the pin logic |
| rsp_rdata | output | 32 | Registered read data |
| rsp_err | output | 1 | One-cycle error pulse for an unmapped or misaligned access |
| out_o | output | 32 | Output latch |
| dir_o | output | 32 | Direction register (1 = output) |
| cfg_o | output | 1024 | Configuration words, word n in bits 32n+31..32n |

## Verification
The hardest state to reach is the one where the two direction views have been changed from both sides, so that a configuration word has upper bits written through its own address and bit 0 later changed by a port-wide direction write. The stimulus table writes configuration words between set, clear and replace writes of the direction register. It then reads back both the configuration words and the direction register. The check passes only if the upper bits survived and both views agree. Misaligned, past-the-end and write-to-input accesses come after this point, so that the check that nothing changed is made against state that is not at its reset value.

// File: rtl/gpio_port_regs_pkg.sv
package gpio_port_regs_pkg;

    // Kind of access the address decoder recognised
    typedef enum logic [3:0] {
        ACC_NONE,
        ACC_OUT,
        ACC_OUT_SET,
        ACC_OUT_CLR,
        ACC_PINS,
        ACC_DIR,
        ACC_DIR_SET,
        ACC_DIR_CLR,
        ACC_CFG,
        ACC_BAD
    } acc_kind_e;

    // Update rule applied to a maskable register
    typedef enum logic [1:0] {
        UPD_HOLD,
        UPD_REPLACE,
        UPD_SET,
        UPD_CLEAR
    } upd_op_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_port_regs_pkg::*;
#(
    parameter int AW       = 12,
    parameter int NPINS    = 32,
    parameter int IW       = 5,
    parameter int OUT_OFS  = 'h504,
    parameter int PINS_OFS = 'h510,
    parameter int DIR_OFS  = 'h514,
    parameter int CFG_OFS  = 'h700
) (
    input  logic          valid,
    input  logic          write,
    input  logic [AW-1:0] addr,
    output acc_kind_e     kind,
    output logic [IW-1:0] idx,
    output upd_op_e       out_op,
    output upd_op_e       dir_op
);

    localparam int CFG_LAST = CFG_OFS + 4 * (NPINS - 1);

    logic aligned;
    logic cfg_hit;

    assign aligned = (addr[1:0] == 2'b00);
    assign cfg_hit = (addr >= AW'(CFG_OFS)) && (addr <= AW'(CFG_LAST));
    assign idx     = IW'((addr - AW'(CFG_OFS)) >> 2);

    always_comb begin
        kind = ACC_BAD;
        if (!valid) begin
            kind = ACC_NONE;
        end else if (aligned) begin
            if      (addr == AW'(OUT_OFS))     kind = ACC_OUT;
            else if (addr == AW'(OUT_OFS + 4)) kind = ACC_OUT_SET;
            else if (addr == AW'(OUT_OFS + 8)) kind = ACC_OUT_CLR;
            else if (addr == AW'(PINS_OFS))    kind = write ? ACC_BAD : ACC_PINS;
            else if (addr == AW'(DIR_OFS))     kind = ACC_DIR;
            else if (addr == AW'(DIR_OFS + 4)) kind = ACC_DIR_SET;
            else if (addr == AW'(DIR_OFS + 8)) kind = ACC_DIR_CLR;
            else if (cfg_hit)                  kind = ACC_CFG;
        end
    end

    always_comb begin
        out_op = UPD_HOLD;
        dir_op = UPD_HOLD;
        if (write) begin
            unique case (kind)
                ACC_OUT:     out_op = UPD_REPLACE;
                ACC_OUT_SET: out_op = UPD_SET;
                ACC_OUT_CLR: out_op = UPD_CLEAR;
                ACC_DIR:     dir_op = UPD_REPLACE;
                ACC_DIR_SET: dir_op = UPD_SET;
                ACC_DIR_CLR: dir_op = UPD_CLEAR;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_mask_update.sv
module gpio_mask_update
    import gpio_port_regs_pkg::*;
#(
    parameter int W = 32
) (
    input  upd_op_e      op,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] nxt
);

    always_comb begin
        unique case (op)
            UPD_REPLACE: nxt = wdata;
            UPD_SET:     nxt = cur | wdata;
            UPD_CLEAR:   nxt = cur & ~wdata;
            default:     nxt = cur;
        endcase
    end

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_port_regs_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NPINS = 32,
    parameter int IW    = 5
) (
    input  acc_kind_e                       kind,
    input  logic [IW-1:0]                   idx,
    input  logic [NPINS-1:0]                out_val,
    input  logic [NPINS-1:0]                dir_val,
    input  logic [NPINS-1:0]                pin_val,
    input  logic [NPINS-1:0][DW-1:1]        cfg_hi,
    output logic [DW-1:0]                   rdata
);

    always_comb begin
        unique case (kind)
            ACC_OUT, ACC_OUT_SET, ACC_OUT_CLR: rdata = DW'(out_val);
            ACC_DIR, ACC_DIR_SET, ACC_DIR_CLR: rdata = DW'(dir_val);
            ACC_PINS:                          rdata = DW'(pin_val);
            ACC_CFG:                           rdata = {cfg_hi[idx], dir_val[idx]};
            default:                           rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_regs_pkg::*;
#(
    parameter int AW       = 12,
    parameter int NPINS    = 32,
    parameter int OUT_OFS  = 'h504,
    parameter int PINS_OFS = 'h510,
    parameter int DIR_OFS  = 'h514,
    parameter int CFG_OFS  = 'h700,
    parameter int CFG_RST  = 'h2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [AW-1:0]         req_addr,
    input  logic [31:0]           req_wdata,
    input  logic [NPINS-1:0]      pad_in,
    output logic [31:0]           rsp_rdata,
    output logic                  rsp_err,
    output logic [NPINS-1:0]      out_o,
    output logic [NPINS-1:0]      dir_o,
    output logic [NPINS*32-1:0]   cfg_o
);

    localparam int DW = 32;
    localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1;
    localparam logic [DW-1:0] CFG_RST_W = DW'(CFG_RST);

    typedef struct packed {
        logic [NPINS-1:0]         out;
        logic [NPINS-1:0]         dir;
        logic [NPINS-1:0]         pins;
        logic [NPINS-1:0][DW-1:1] cfg_hi;
        logic [DW-1:0]            rdata;
        logic                     err;
    } state_t;

    state_t s_d, s_q;

    acc_kind_e        kind;
    logic [IW-1:0]    idx;
    upd_op_e          out_op, dir_op;
    logic [NPINS-1:0] out_nxt, dir_nxt;
    logic [DW-1:0]    rd_val;

    gpio_addr_decode #(
        .AW(AW), .NPINS(NPINS), .IW(IW),
        .OUT_OFS(OUT_OFS), .PINS_OFS(PINS_OFS),
        .DIR_OFS(DIR_OFS), .CFG_OFS(CFG_OFS)
    ) u_dec (
        .valid  (req_valid),
        .write  (req_write),
        .addr   (req_addr),
        .kind   (kind),
        .idx    (idx),
        .out_op (out_op),
        .dir_op (dir_op)
    );

    gpio_mask_update #(.W(NPINS)) u_out_upd (
        .op    (out_op),
        .cur   (s_q.out),
        .wdata (req_wdata[NPINS-1:0]),
        .nxt   (out_nxt)
    );

    gpio_mask_update #(.W(NPINS)) u_dir_upd (
        .op    (dir_op),
        .cur   (s_q.dir),
        .wdata (req_wdata[NPINS-1:0]),
        .nxt   (dir_nxt)
    );

    gpio_read_mux #(.DW(DW), .NPINS(NPINS), .IW(IW)) u_rd (
        .kind    (kind),
        .idx     (idx),
        .out_val (s_q.out),
        .dir_val (s_q.dir),
        .pin_val (s_q.pins),
        .cfg_hi  (s_q.cfg_hi),
        .rdata   (rd_val)
    );

    always_comb begin
        s_d      = s_q;
        s_d.pins = pad_in;
        s_d.err  = (kind == ACC_BAD);
        s_d.out  = out_nxt;
        s_d.dir  = dir_nxt;
        if (kind == ACC_CFG && req_write) begin
            s_d.cfg_hi[idx] = req_wdata[DW-1:1];
            s_d.dir[idx]    = req_wdata[0];
        end
        if (req_valid && !req_write) begin
            s_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int n = 0; n < NPINS; n++) begin
                s_q.cfg_hi[n] <= CFG_RST_W[DW-1:1];
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_rdata = s_q.rdata;
    assign rsp_err   = s_q.err;
    assign out_o     = s_q.out;
    assign dir_o     = s_q.dir;

    for (genvar n = 0; n < NPINS; n++) begin : g_cfg
        assign cfg_o[n*DW +: DW] = {s_q.cfg_hi[n], s_q.dir[n]};
    end

endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
    parameter int AW       = 12,
    parameter int NPINS    = 32,
    parameter int OUT_OFS  = 'h504,
    parameter int PINS_OFS = 'h510,
    parameter int DIR_OFS  = 'h514,
    parameter int CFG_OFS  = 'h700
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_write,
    input logic [AW-1:0]       req_addr,
    input logic [31:0]         req_wdata,
    input logic                rsp_err,
    input logic [NPINS-1:0]    out_o,
    input logic [NPINS-1:0]    dir_o
);

    localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1;
    localparam int CFG_END = CFG_OFS + 4 * NPINS;

    logic          wr;
    logic          cfg_in;
    logic          known;
    logic [IW-1:0] cidx;

    assign wr     = req_valid && req_write;
    assign cfg_in = (req_addr[1:0] == 2'b00) && (req_addr >= AW'(CFG_OFS))
                    && (req_addr < AW'(CFG_END));
    assign cidx   = IW'((req_addr - AW'(CFG_OFS)) >> 2);
    assign known  = cfg_in
                    || (req_addr == AW'(OUT_OFS)) || (req_addr == AW'(OUT_OFS + 4))
                    || (req_addr == AW'(OUT_OFS + 8)) || (req_addr == AW'(DIR_OFS))
                    || (req_addr == AW'(DIR_OFS + 4)) || (req_addr == AW'(DIR_OFS + 8))
                    || (req_addr == AW'(PINS_OFS) && !req_write);

    AST_OUT_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
        wr && req_addr == AW'(OUT_OFS) |=> out_o == $past(req_wdata[NPINS-1:0])); // R1
    AST_OUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr && req_addr == AW'(OUT_OFS + 4) |=> out_o == ($past(out_o) | $past(req_wdata[NPINS-1:0]))); // R2
    AST_OUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wr && req_addr == AW'(OUT_OFS + 8) |=> out_o == ($past(out_o) & ~$past(req_wdata[NPINS-1:0]))); // R3
    AST_DIR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr && req_addr == AW'(DIR_OFS + 4) |=> dir_o == ($past(dir_o) | $past(req_wdata[NPINS-1:0]))); // R4
    AST_CFG_TO_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        wr && cfg_in |=> dir_o[$past(cidx)] == $past(req_wdata[0])); // R6
    AST_BAD_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !known |=> rsp_err && out_o == $past(out_o) && dir_o == $past(dir_o)); // R9
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_err); // R11

endmodule

bind gpio_port_regs gpio_port_regs_chk #(
    .AW(AW), .NPINS(NPINS), .OUT_OFS(OUT_OFS), .PINS_OFS(PINS_OFS),
    .DIR_OFS(DIR_OFS), .CFG_OFS(CFG_OFS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_err   (rsp_err),
    .out_o     (out_o),
    .dir_o     (dir_o)
);

// File: tb/gpio_port_regs_tb.sv
module gpio_port_regs_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [11:0]   req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [31:0]   pad_in = '0;
    logic [31:0]   rsp_rdata;
    logic          rsp_err;
    logic [31:0]   out_o;
    logic [31:0]   dir_o;
    logic [NP*32-1:0] cfg_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    gpio_port_regs u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .pad_in(pad_in),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .out_o(out_o),
        .dir_o(dir_o), .cfg_o(cfg_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h504, 32'hA5A5_0F0F, 32'h0,          8'd1},
        '{1'b0, 12'h504, 32'h0,          32'hA5A5_0F0F, 8'd1},  // R1
        '{1'b1, 12'h508, 32'h0000_F0F0, 32'h0,          8'd2},
        '{1'b0, 12'h50C, 32'h0,          32'hA5A5_FFFF, 8'd2},  // R2
        '{1'b1, 12'h50C, 32'hA000_000F, 32'h0,          8'd3},
        '{1'b0, 12'h508, 32'h0,          32'h05A5_FFF0, 8'd3},  // R3
        '{1'b1, 12'h514, 32'h0000_00FF, 32'h0,          8'd4},
        '{1'b1, 12'h518, 32'h0001_0000, 32'h0,          8'd4},
        '{1'b1, 12'h51C, 32'h0000_000F, 32'h0,          8'd4},
        '{1'b0, 12'h514, 32'h0,          32'h0001_00F0, 8'd4},  // R4
        '{1'b0, 12'h700, 32'h0,          32'h0000_0002, 8'd5},  // R5
        '{1'b0, 12'h710, 32'h0,          32'h0000_0003, 8'd5},  // R5
        '{1'b0, 12'h740, 32'h0,          32'h0000_0003, 8'd5},  // R5
        '{1'b1, 12'h704, 32'h1234_5679, 32'h0,          8'd6},
        '{1'b0, 12'h514, 32'h0,          32'h0001_00F2, 8'd6},  // R6
        '{1'b0, 12'h704, 32'h0,          32'h1234_5679, 8'd6},  // R6
        '{1'b1, 12'h710, 32'h0000_0000, 32'h0,          8'd6},
        '{1'b0, 12'h51C, 32'h0,          32'h0001_00E2, 8'd6},  // R6 R7
        '{1'b1, 12'h514, 32'h0000_0000, 32'h0,          8'd5},
        '{1'b0, 12'h704, 32'h0,          32'h1234_5678, 8'd5},  // R5
        '{1'b0, 12'h518, 32'h0,          32'h0000_0000, 8'd7}   // R7
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // One access: driven after a falling edge, results visible at the next falling edge
    task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
        end
    end

    initial begin
        logic [31:0] snap_out, snap_dir;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 out", out_o, 32'h0);
        check("R10 dir", dir_o, 32'h0);
        check("R10 err", {31'b0, rsp_err}, 32'h0);
        check("R10 cfg0", cfg_o[31:0], 32'h2);
        check("R10 cfg31", cfg_o[31*32 +: 32], 32'h2);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].addr, VECS[i].data);
            if (!VECS[i].wr) begin
                check($sformatf("R%0d table row %0d", VECS[i].req, i), rsp_rdata, VECS[i].exp);
                check($sformatf("R%0d table row %0d err", VECS[i].req, i), {31'b0, rsp_err}, 32'h0);
            end
        end

        // R1 latch visible on the port; R5 word 1 keeps its upper bits
        check("R1 out_o port", out_o, 32'h05A5_FFF0);
        check("R5 cfg_o word1", cfg_o[32 +: 32], 32'h1234_5678);

        // R11 read data holds across a write
        access(1'b1, 12'h504, 32'h0F0F_0000);
        check("R11 rdata held", rsp_rdata, 32'h0000_0000);
        check("R1 out_o after replace", out_o, 32'h0F0F_0000);

        // R8 pin capture and write to input
        pad_in = 32'hDEAD_BEEF;
        access(1'b0, 12'h510, 32'h0);
        check("R8 input read", rsp_rdata, 32'hDEAD_BEEF);
        snap_out = out_o; snap_dir = dir_o;
        access(1'b1, 12'h510, 32'hFFFF_FFFF);
        check("R8 write to input err", {31'b0, rsp_err}, 32'h1);
        check("R8 write to input out", out_o, snap_out);

        // R9 unmapped read, unmapped write, misaligned, past end
        access(1'b0, 12'h600, 32'h0);
        check("R9 unmapped read data", rsp_rdata, 32'h0);
        check("R9 unmapped read err", {31'b0, rsp_err}, 32'h1);
        idle();
        check("R11 err clears", {31'b0, rsp_err}, 32'h0);
        access(1'b1, 12'h600, 32'hFFFF_FFFF);
        check("R9 unmapped write out", out_o, snap_out);
        check("R9 unmapped write dir", dir_o, snap_dir);
        access(1'b1, 12'h505, 32'hFFFF_FFFF);
        check("R9 misaligned err", {31'b0, rsp_err}, 32'h1);
        check("R9 misaligned out", out_o, snap_out);
        access(1'b1, 12'h780, 32'hFFFF_FFFF);
        check("R9 past config end err", {31'b0, rsp_err}, 32'h1);
        check("R9 past config end dir", dir_o, snap_dir);
        access(1'b0, 12'h77C, 32'h0);
        check("R9 last config word intact", rsp_rdata, 32'h2);

        // R10 reset in the middle of a run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R10 out after reset", out_o, 32'h0);
        check("R10 cfg1 after reset", cfg_o[32 +: 32], 32'h2);
        rst_n = 1'b1;
        pad_in = 32'h0;
        access(1'b0, 12'h510, 32'h0);
        check("R10 input after reset", rsp_rdata, 32'h0);

        done = 1'b1;
        summary();
    end

endmodule